// File: doc/BRIEF.md
# Logical-to-Physical Page Translator

This block turns a processor address inside a 32 MB logical window into a physical RAM address using a page table that software loads one entry at a time. The page size is set through a control-register write and can be 4, 8, 16 or 32 KB. Each table entry is loaded by a single write word. That word packs a logical page number, a physical page number whose bit order depends on the page size, two permission bits and a controller-select bit. The translator decodes these fields and stores the physical page together with a separate valid bit.

After reset a boot overlay is active. Logical reads are steered to ROM at the address modulo 2 MB, and logical writes go nowhere. The first table write of any kind turns the overlay off for good, until the next reset. After that, each access either translates to a physical address with the mapped flag set, or finds no valid entry. In that case the flags stay low, so the surrounding fabric returns zero on a read and drops a write.

The table holds `DEPTH` entries indexed by logical page number. Logical pages at or above `DEPTH` are never mapped.

Top module: `ptx_top`

## Requirements
- R1: After reset the overlay is active, the page size is 4 KB, and no table entry is valid.
- R2: With the overlay active, a read strobe to a logical address (bits 31:25 all zero) raises rom_sel_o with phys_addr_o equal to address bits 20:0. A write with no read raises neither flag.
- R3: A control word counts only when its bits 27:21 equal 7'h1B and its bits 19:17 equal 3'd7. Its bits 3:2 then select the page size (0 = 4 KB, 1 = 8 KB, 2 = 16 KB, 3 = 32 KB). Any other control word changes nothing.
- R4: Any entry write clears the overlay from the next cycle on. A control write leaves the overlay unchanged.
- R5: The logical page of an entry word is {w[11:10], w[22:12]} shifted right by the size code. This discards the low bits that larger pages do not use.
- R6: The physical page p[6:0] is decoded from w[6:0] by size. 4 KB: p = w[6:0]. 8 KB: p[5:0] = w[6:1], p[6] = w[0]. 16 KB: p[4:0] = w[6:2], p[6:5] = w[1:0]. 32 KB: p[3:0] = w[6:3], p[4] = w[0], p[5] = w[2], p[6] = w[1].
- R7: With the overlay off, a read or write to a logical page with a valid entry raises mapped_o. phys_addr_o is then the physical page times the page size plus the offset within the page.
- R8: An access to a logical page whose entry is not valid leaves mapped_o and rom_sel_o low and drives phys_addr_o to zero.
- R9: Entry bits 9:8 (permission) and bit 7 (controller select) do not affect translation. A later write to the same logical page replaces the earlier entry.
- R10: An address with any of bits 31:25 set raises neither flag.
- R11: An entry write whose logical page is DEPTH or more stores nothing, but still clears the overlay.
- R12: With neither read nor write strobe, both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Access address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_word_i | input | 32 | Control word (decode bits and page-size field) |
| ent_we_i | input | 1 | Table entry write strobe |
| ent_word_i | input | 32 | Table entry word |
| phys_addr_o | output | 22 | Translated physical address, or ROM address under the overlay |
| mapped_o | output | 1 | Access hits a valid table entry |
| rom_sel_o | output | 1 | Read is steered to boot ROM |

## Verification
A wrong valid bit or stored page shows in the same cycle as any access to that logical page. It appears as a flag that should not be set or as a physical address in the wrong page. A wrong field decode in an entry write surfaces only when the affected page is read back at that page size, so every size is swept over all table pages and one page beyond. An overlay that stays on, or drops too early, shows up at the very next logical read as rom_sel_o set or cleared when it should not be.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

   localparam int PPN_W       = 7;
   localparam int MIN_PG_BITS = 12;
   localparam int MAX_PG_BITS = 15;
   localparam int LOG_BITS    = 25;
   localparam int LPN_W       = LOG_BITS - MIN_PG_BITS;

   typedef enum logic [1:0] {
      PG_4K  = 2'd0,
      PG_8K  = 2'd1,
      PG_16K = 2'd2,
      PG_32K = 2'd3
   } pg_size_e;

   function automatic logic [PPN_W-1:0] unscramble_ppn(input logic [PPN_W-1:0] f,
                                                       input pg_size_e s);
      logic [PPN_W-1:0] p;
      unique case (s)
         PG_4K:   p = f;
         PG_8K:   p = {f[0], f[6:1]};
         PG_16K:  p = {f[1:0], f[6:2]};
         default: p = {f[1], f[2], f[0], f[6:3]};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/ptx_ctl.sv
module ptx_ctl
   import ptx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_we_i,
   input  logic [31:0] ctl_word_i,
   input  logic        ent_we_i,
   output pg_size_e    size_o,
   output logic        overlay_o
);

   pg_size_e size_q;
   logic     overlay_q;
   logic     ctl_hit;
   logic     unused_ctl;

   assign ctl_hit    = ctl_we_i && (ctl_word_i[27:21] == 7'h1B) && (ctl_word_i[19:17] == 3'd7);
   assign unused_ctl = ^{ctl_word_i[31:28], ctl_word_i[20], ctl_word_i[16:4], ctl_word_i[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q    <= PG_4K;
         overlay_q <= 1'b1;
      end else begin
         if (ctl_hit)  size_q    <= pg_size_e'(ctl_word_i[3:2]);
         if (ent_we_i) overlay_q <= 1'b0;
      end
   end

   assign size_o    = size_q;
   assign overlay_o = overlay_q;

   assert_overlay_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ent_we_i |=> !overlay_q);
   assert_overlay_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !overlay_q |=> !overlay_q);
   assert_size_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we_i |=> $stable(size_q));

endmodule

// File: rtl/ptx_table.sv
module ptx_table
   import ptx_pkg::*;
#(
   parameter  int DEPTH = 128,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ent_we_i,
   input  logic [31:0]      ent_word_i,
   input  pg_size_e         size_i,
   input  logic [LPN_W-1:0] lk_lpn_i,
   output logic             lk_valid_o,
   output logic [PPN_W-1:0] lk_ppn_o
);

   localparam logic [LPN_W:0] DEPTH_L = (LPN_W+1)'(DEPTH);

   logic [DEPTH-1:0] vld_q;
   logic [PPN_W-1:0] ppn_q [DEPTH];
   logic [LPN_W-1:0] raw_lpn, wr_lpn;
   logic [IDX_W-1:0] wr_idx, lk_idx;
   logic [PPN_W-1:0] ppn_new;
   logic             wr_in_range, lk_in_range, do_wr;
   logic             unused_ent;

   assign raw_lpn     = {ent_word_i[11:10], ent_word_i[22:12]};
   assign wr_lpn      = raw_lpn >> size_i;
   assign wr_in_range = {1'b0, wr_lpn} < DEPTH_L;
   assign wr_idx      = wr_lpn[IDX_W-1:0];
   assign ppn_new     = unscramble_ppn(ent_word_i[6:0], size_i);
   assign do_wr       = ent_we_i && wr_in_range;
   assign unused_ent  = ^{ent_word_i[31:23], ent_word_i[9:7]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q         <= '0;
      else if (do_wr) vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_wr) ppn_q[wr_idx] <= ppn_new;
   end

   assign lk_in_range = {1'b0, lk_lpn_i} < DEPTH_L;
   assign lk_idx      = lk_lpn_i[IDX_W-1:0];
   assign lk_valid_o  = lk_in_range && vld_q[lk_idx];
   assign lk_ppn_o    = ppn_q[lk_idx];

   assert_entry_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      do_wr |=> vld_q[$past(wr_idx)]);
   assert_oob_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !do_wr |=> $stable(vld_q));

endmodule

// File: rtl/ptx_lookup.sv
module ptx_lookup
   import ptx_pkg::*;
#(
   parameter int ROM_BITS = 21,
   parameter int PA_W     = 22
) (
   input  logic [31:0]      addr_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  pg_size_e         size_i,
   input  logic             overlay_i,
   input  logic             lk_valid_i,
   input  logic [PPN_W-1:0] lk_ppn_i,
   output logic [LPN_W-1:0] lk_lpn_o,
   output logic [PA_W-1:0]  phys_addr_o,
   output logic             mapped_o,
   output logic             rom_sel_o
);

   logic            in_logical, any_acc;
   logic [4:0]      pg_shift;
   logic [PA_W-1:0] off_mask, page_base, xlated;

   assign in_logical = (addr_i[31:LOG_BITS] == '0);
   assign any_acc    = rd_i || wr_i;
   assign lk_lpn_o   = addr_i[LOG_BITS-1:MIN_PG_BITS] >> size_i;

   assign pg_shift   = 5'(MIN_PG_BITS) + {3'b000, size_i};
   assign off_mask   = ~({PA_W{1'b1}} << pg_shift);
   assign page_base  = PA_W'(lk_ppn_i) << pg_shift;
   assign xlated     = page_base | (PA_W'(addr_i[MAX_PG_BITS-1:0]) & off_mask);

   assign rom_sel_o  = in_logical && overlay_i && rd_i;
   assign mapped_o   = in_logical && !overlay_i && any_acc && lk_valid_i;

   always_comb begin
      if (rom_sel_o)     phys_addr_o = PA_W'(addr_i[ROM_BITS-1:0]);
      else if (mapped_o) phys_addr_o = xlated;
      else               phys_addr_o = '0;
   end

endmodule

// File: rtl/ptx_top.sv
module ptx_top
   import ptx_pkg::*;
#(
   parameter  int DEPTH    = 128,
   parameter  int ROM_BITS = 21,
   localparam int PA_W     = (PPN_W + MAX_PG_BITS > ROM_BITS) ? PPN_W + MAX_PG_BITS : ROM_BITS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     addr_i,
   input  logic            rd_i,
   input  logic            wr_i,
   input  logic            ctl_we_i,
   input  logic [31:0]     ctl_word_i,
   input  logic            ent_we_i,
   input  logic [31:0]     ent_word_i,
   output logic [PA_W-1:0] phys_addr_o,
   output logic            mapped_o,
   output logic            rom_sel_o
);

   generate
      if (DEPTH < 2 || DEPTH > (1 << LPN_W) || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ptx_top: DEPTH must be a power of two between 2 and 2**LPN_W");
      end
      if (ROM_BITS < MIN_PG_BITS || ROM_BITS > LOG_BITS) begin : g_bad_rom
         $error("ptx_top: ROM_BITS out of range");
      end
   endgenerate

   pg_size_e         size;
   logic             overlay;
   logic             lk_valid;
   logic [PPN_W-1:0] lk_ppn;
   logic [LPN_W-1:0] lk_lpn;

   ptx_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we_i  (ctl_we_i),
      .ctl_word_i(ctl_word_i),
      .ent_we_i  (ent_we_i),
      .size_o    (size),
      .overlay_o (overlay)
   );

   ptx_table #(.DEPTH(DEPTH)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .ent_we_i  (ent_we_i),
      .ent_word_i(ent_word_i),
      .size_i    (size),
      .lk_lpn_i  (lk_lpn),
      .lk_valid_o(lk_valid),
      .lk_ppn_o  (lk_ppn)
   );

   ptx_lookup #(.ROM_BITS(ROM_BITS), .PA_W(PA_W)) u_lookup (
      .addr_i     (addr_i),
      .rd_i       (rd_i),
      .wr_i       (wr_i),
      .size_i     (size),
      .overlay_i  (overlay),
      .lk_valid_i (lk_valid),
      .lk_ppn_i   (lk_ppn),
      .lk_lpn_o   (lk_lpn),
      .phys_addr_o(phys_addr_o),
      .mapped_o   (mapped_o),
      .rom_sel_o  (rom_sel_o)
   );

   assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_i || wr_i) |-> !mapped_o && !rom_sel_o);
   assert_overlay_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !rd_i) |-> !rom_sel_o);
   assert_rom_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rom_sel_o |-> phys_addr_o == PA_W'(addr_i[ROM_BITS-1:0]));
   assert_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mapped_o |-> phys_addr_o[MIN_PG_BITS-1:0] == addr_i[MIN_PG_BITS-1:0]);
   assert_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i[31:LOG_BITS] != '0) |-> !mapped_o && !rom_sel_o);
   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mapped_o && !rom_sel_o) |-> phys_addr_o == '0);

endmodule

// File: tb/ptx_top_tb.sv
module ptx_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int PA_W       = 22;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [31:0]     addr_i = '0;
   logic            rd_i = 1'b0, wr_i = 1'b0;
   logic            ctl_we_i = 1'b0, ent_we_i = 1'b0;
   logic [31:0]     ctl_word_i = '0, ent_word_i = '0;
   logic [PA_W-1:0] phys_addr_o;
   logic            mapped_o, rom_sel_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   int exp_ppn [DEPTH+1];
   bit exp_vld [DEPTH+1];

   always #(CLK_PERIOD/2) clk = ~clk;

   ptx_top #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
      .ctl_we_i(ctl_we_i), .ctl_word_i(ctl_word_i),
      .ent_we_i(ent_we_i), .ent_word_i(ent_word_i),
      .phys_addr_o(phys_addr_o), .mapped_o(mapped_o), .rom_sel_o(rom_sel_o)
   );

   function automatic logic [31:0] mk_entry(int lpn, int ppn, int s, int perm, int sel, int junk);
      logic [12:0] l = 13'(lpn << s) | 13'(junk & ((1 << s) - 1));
      logic [6:0]  p = 7'(ppn);
      logic [6:0]  f;
      logic [31:0] w = 32'h0380_0000;
      case (s)
         0:       f = p;
         1:       f = {p[5:0], p[6]};
         2:       f = {p[4:0], p[6:5]};
         default: f = {p[3:0], p[5], p[6], p[4]};
      endcase
      w[22:12] = l[10:0];
      w[11:10] = l[12:11];
      w[9:8]   = 2'(perm);
      w[7]     = sel[0];
      w[6:0]   = f;
      return w;
   endfunction

   function automatic logic [31:0] mk_ctl(int s, bit good);
      logic [31:0] w = 32'h0000_0000;
      w[27:21] = 7'h1B;
      w[19:17] = good ? 3'd7 : 3'd6;
      w[3:2]   = 2'(s);
      w[11]    = 1'b1;
      return w;
   endfunction

   task automatic check_out(string req, bit e_map, bit e_rom, logic [PA_W-1:0] e_pa);
      n_checks++;
      if (mapped_o !== e_map || rom_sel_o !== e_rom || phys_addr_o !== e_pa) begin
         n_fails++;
         $display("FAIL %s addr=%h: actual map=%b rom=%b pa=%h expected map=%b rom=%b pa=%h",
                  req, addr_i, mapped_o, rom_sel_o, phys_addr_o, e_map, e_rom, e_pa);
      end
   endtask

   task automatic access(logic [31:0] a, bit r, bit w);
      @(negedge clk);
      addr_i = a; rd_i = r; wr_i = w;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      rd_i = 1'b0; wr_i = 1'b0;
   endtask

   task automatic ent_write(logic [31:0] w);
      @(negedge clk);
      rd_i = 1'b0; wr_i = 1'b0;
      ent_we_i = 1'b1; ent_word_i = w;
      @(negedge clk);
      ent_we_i = 1'b0;
   endtask

   task automatic ctl_write(logic [31:0] w);
      @(negedge clk);
      ctl_we_i = 1'b1; ctl_word_i = w;
      @(negedge clk);
      ctl_we_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic expect_page(int s, int l, int off, bit r, bit w, string req);
      logic [31:0]     a = 32'(l << (12 + s)) + 32'(off);
      logic [PA_W-1:0] pa = exp_vld[l] ? PA_W'((exp_ppn[l] << (12 + s)) + off) : '0;
      access(a, r, w);
      check_out(req, exp_vld[l], 1'b0, pa);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         do_reset();
         // R1 / R2: overlay after reset
         access(32'h0000_0000, 1'b1, 1'b0);
         check_out("R1 overlay at reset", 1'b0, 1'b1, '0);
         access(32'h0123_4567, 1'b1, 1'b0);
         check_out("R2 overlay read mod 2MB", 1'b0, 1'b1, PA_W'(32'h0003_4567));
         access(32'h0123_4567, 1'b0, 1'b1);
         check_out("R2 overlay write ignored", 1'b0, 1'b0, '0);
         access(32'h0340_0000, 1'b1, 1'b0);
         check_out("R10 outside logical under overlay", 1'b0, 1'b0, '0);
         idle();

         // R3: valid size write, then a non-matching control word
         ctl_write(mk_ctl(s, 1'b1));
         ctl_write(mk_ctl((s + 1) % 4, 1'b0));
         access(32'h0000_0100, 1'b1, 1'b0);
         check_out("R4 control write keeps overlay", 1'b0, 1'b1, PA_W'(32'h100));
         idle();

         for (int l = 0; l <= DEPTH; l++) begin
            exp_vld[l] = 1'b0;
            exp_ppn[l] = 0;
         end

         // R5 / R6 / R9: load table
         for (int l = 0; l < DEPTH; l++) begin
            if (l % 3 != 2) begin
               exp_vld[l] = 1'b1;
               exp_ppn[l] = (l * 37 + s * 11 + 5) % 128;
               ent_write(mk_entry(l, exp_ppn[l], s, l % 4, l % 2, l));
               if (l == 0) begin
                  access(32'h0000_0000, 1'b1, 1'b0);
                  check_out("R4 first entry clears overlay", 1'b1, 1'b0,
                            PA_W'(exp_ppn[0] << (12 + s)));
                  idle();
               end
            end
         end
         // R11: out-of-range page write stores nothing
         ent_write(mk_entry(DEPTH, 3, s, 0, 0, 0));
         // R9: overwrite with different permission / select bits
         exp_ppn[1] = (s * 5 + 99) % 128;
         ent_write(mk_entry(1, exp_ppn[1], s, 3, 1, 0));

         // R7 / R8 / R11 sweep
         for (int l = 0; l <= DEPTH; l++) begin
            expect_page(s, l, 3, 1'b1, 1'b0, "R7 R8 R11 R6 read");
            expect_page(s, l, (1 << (12 + s)) - 1, 1'b0, 1'b1, "R7 R8 R11 R6 write");
            expect_page(s, l, (1 << (11 + s)) + 5, 1'b1, 1'b0, "R5 R9 mid-page");
         end

         // R12: no strobe
         access(32'h0000_0000, 1'b0, 1'b0);
         check_out("R12 no strobe", 1'b0, 1'b0, '0);
         // R10: outside logical window
         access(32'h0200_0010, 1'b1, 1'b0);
         check_out("R10 outside window", 1'b0, 1'b0, '0);
         // R11: high logical page beyond table
         access(32'h01FF_F000, 1'b1, 1'b0);
         check_out("R11 high logical page", 1'b0, 1'b0, '0);
         idle();
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule